// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block receives asynchronous serial frames on a single line and hands each byte to a processor through a data register and a small status word. The line first passes through a two-flop synchronizer. A free-running divider makes a tick at sixteen times the bit rate. The receive engine confirms a start bit half a bit after the falling edge, then samples each data bit, the optional parity bit and the stop bit at its centre.

Completed frames update four status flags: data-full, overrun, parity error and framing error. A receive interrupt request pulses whenever data-full becomes set. Software clears flags by writing zeros, and a transfer-controller read strobe clears data-full on its own. While any error flag is set the engine is held idle and no frame is accepted. The synchronized line level is always visible, so software can tell a break (line held low) from a single bad frame.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset `stat` is 0 and `rx_data` is 0. The `stat` bits are: bit 0 data-full, bit 1 overrun, bit 2 parity error, bit 3 framing error.
- R2: While any of `stat[3:1]` is 1, incoming frames are neither stored nor flagged. Reception restarts once all three bits are 0.
- R3: `rx_irq` is high for exactly one cycle, in the cycle in which `stat[0]` changes from 0 to 1, and at no other time.
- R4: A `stat_wr` pulse clears every flag whose `stat_wdata` bit is 0. A 1 bit leaves that flag unchanged and never sets it.
- R5: A `dtc_rd` pulse clears `stat[0]` and leaves the error flags unchanged.
- R6: If `stat[0]` is still 1 when the stop bit of a frame is sampled, `stat[1]` is set, `rx_data` keeps the old byte and `stat[0]` stays 1.
- R7: While `rx_en` is 0 the engine stays idle and frames on `rx_line` change no flag and no data.
- R8: `line_mon` shows the synchronized `rx_line` level two cycles late, whatever the flags hold. It therefore reads 0 during a break that raised a framing error.
- R9: A frame is a low start bit, 8 data bits LSB first, an optional parity bit, then a stop bit. A bit lasts 16 ticks. A low pulse that is gone by the start-bit centre is not taken as a frame.
- R10: With `par_en`=1 a parity bit follows the data. It is chosen so the number of ones in data plus parity is even (`par_odd`=0) or odd (`par_odd`=1). A mismatch sets `stat[2]`, stores the byte and leaves `stat[0]` at 0.
- R11: A stop bit sampled as 0 sets `stat[3]`, stores the byte and leaves `stat[0]` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 4 | Status write value; a 0 clears that flag |
| dtc_rd | input | 1 | Transfer-controller read of the data register |
| rx_data | output | 8 | Last stored byte |
| stat | output | 4 | Flags: full, overrun, parity, framing |
| rx_irq | output | 1 | One-cycle pulse when data-full sets |
| line_mon | output | 1 | Synchronized line level |

## Verification
The checker watches several rules on every cycle:
- the interrupt pulse matches each rising edge of data-full;
- the data register holds still while data-full is set and while an error flag is set;
- error flags never clear without a status write;
- a transfer-controller read always empties data-full;
- nothing is received while disabled.

Only the bench scenarios can show the rest, because each needs a known frame on the line and a known expected byte:
- correct bit order and parity decisions;
- rejection of a short start glitch;
- the flags and byte left by a break;
- a clean restart after the error flags are cleared.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int SRX_DW   = 8;
    localparam int SRX_NFLG = 4;

    localparam int FLG_FULL = 0;
    localparam int FLG_OVR  = 1;
    localparam int FLG_PAR  = 2;
    localparam int FLG_FRM  = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_t;

    typedef struct packed {
        logic [SRX_DW-1:0] data;
        logic              par_bad;
        logic              stop_bad;
    } frame_t;

    function automatic logic parity_bit(input logic [SRX_DW-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/srx_engine.sv
module srx_engine
    import srx_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4,
    parameter int OVS           = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  logic   line,
    input  logic   par_en,
    input  logic   par_odd,
    output logic   frame_v,
    output frame_t frame
);
    localparam int TW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int BW   = $clog2(SRX_DW);

    logic tick;

    generate
        if (CLKS_PER_TICK == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DIVW = $clog2(CLKS_PER_TICK);
            logic [DIVW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || div_q == DIVW'(CLKS_PER_TICK - 1)) div_q <= '0;
                else                                         div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DIVW'(CLKS_PER_TICK - 1));
        end
    endgenerate

    phase_t            ph_q;
    logic [TW-1:0]     cnt_q;
    logic [BW-1:0]     idx_q;
    logic [SRX_DW-1:0] shr_q;
    logic              par_q;
    logic              at_ctr;

    assign at_ctr = tick && (cnt_q == TW'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
            if (rst) begin
                shr_q <= '0;
                par_q <= 1'b0;
            end
        end else if (tick) begin
            case (ph_q)
                PH_IDLE: begin
                    if (!line) begin
                        ph_q  <= PH_START;
                        cnt_q <= '0;
                    end
                end
                PH_START: begin
                    if (cnt_q == TW'(HALF - 1)) begin
                        cnt_q <= '0;
                        idx_q <= '0;
                        ph_q  <= line ? PH_IDLE : PH_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (at_ctr) begin
                        cnt_q <= '0;
                        shr_q <= {line, shr_q[SRX_DW-1:1]};
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == BW'(SRX_DW - 1))
                            ph_q <= par_en ? PH_PAR : PH_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_PAR: begin
                    if (at_ctr) begin
                        cnt_q <= '0;
                        par_q <= line;
                        ph_q  <= PH_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_STOP: begin
                    if (at_ctr) begin
                        cnt_q <= '0;
                        ph_q  <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign frame_v        = (ph_q == PH_STOP) && at_ctr && !hold;
    assign frame.data     = shr_q;
    assign frame.par_bad  = par_en && (par_q != parity_bit(shr_q, par_odd));
    assign frame.stop_bad = !line;
endmodule

// File: rtl/srx_flags.sv
module srx_flags
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_v,
    input  frame_t              frame,
    input  logic                stat_wr,
    input  logic [SRX_NFLG-1:0] stat_wdata,
    input  logic                dtc_rd,
    output logic [SRX_NFLG-1:0] stat,
    output logic [SRX_DW-1:0]   rx_data,
    output logic                rx_irq,
    output logic                any_err
);
    logic [SRX_NFLG-1:0] stat_q, stat_d;

    always_comb begin
        stat_d = stat_q;
        if (stat_wr) stat_d = stat_d & stat_wdata;
        if (dtc_rd)  stat_d[FLG_FULL] = 1'b0;
        if (frame_v) begin
            if (stat_q[FLG_FULL]) begin
                stat_d[FLG_OVR] = 1'b1;
            end else begin
                if (frame.par_bad)  stat_d[FLG_PAR] = 1'b1;
                if (frame.stop_bad) stat_d[FLG_FRM] = 1'b1;
                if (!frame.par_bad && !frame.stop_bad) stat_d[FLG_FULL] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            rx_data <= '0;
            rx_irq  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            rx_irq <= stat_d[FLG_FULL] && !stat_q[FLG_FULL];
            if (frame_v && !stat_q[FLG_FULL]) rx_data <= frame.data;
        end
    end

    assign stat    = stat_q;
    assign any_err = stat_q[FLG_OVR] | stat_q[FLG_PAR] | stat_q[FLG_FRM];
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4,
    parameter int OVS           = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_line,
    input  logic                rx_en,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                stat_wr,
    input  logic [SRX_NFLG-1:0] stat_wdata,
    input  logic                dtc_rd,
    output logic [SRX_DW-1:0]   rx_data,
    output logic [SRX_NFLG-1:0] stat,
    output logic                rx_irq,
    output logic                line_mon
);
    logic   line_s;
    logic   any_err;
    logic   frame_v;
    frame_t frame;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    srx_engine #(.CLKS_PER_TICK(CLKS_PER_TICK), .OVS(OVS)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .hold    (!rx_en || any_err),
        .line    (line_s),
        .par_en  (par_en),
        .par_odd (par_odd),
        .frame_v (frame_v),
        .frame   (frame)
    );

    srx_flags u_flg (
        .clk        (clk),
        .rst        (rst),
        .frame_v    (frame_v),
        .frame      (frame),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .dtc_rd     (dtc_rd),
        .stat       (stat),
        .rx_data    (rx_data),
        .rx_irq     (rx_irq),
        .any_err    (any_err)
    );

    assign line_mon = line_s;
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       stat_wr,
    input logic       dtc_rd,
    input logic [7:0] rx_data,
    input logic [3:0] stat,
    input logic       rx_irq
);
    AST_IRQ_ON_RISE:   assert property (@(posedge clk) disable iff (rst) $rose(stat[0]) |-> rx_irq);            // R3
    AST_IRQ_ONLY_RISE: assert property (@(posedge clk) disable iff (rst) rx_irq |-> $rose(stat[0]));            // R3
    AST_DATA_KEPT:     assert property (@(posedge clk) disable iff (rst) stat[0] |=> $stable(rx_data));         // R6
    AST_LOCKOUT:       assert property (@(posedge clk) disable iff (rst) (|stat[3:1]) |=> $stable(rx_data));    // R2
    AST_ERR_STICKY:    assert property (@(posedge clk) disable iff (rst)
                           ((|stat[3:1]) && !stat_wr) |=> ((stat[3:1] & $past(stat[3:1])) == $past(stat[3:1]))); // R4
    AST_DTC_CLEARS:    assert property (@(posedge clk) disable iff (rst) (stat[0] && dtc_rd) |=> !stat[0]);     // R5
    AST_DISABLED:      assert property (@(posedge clk) disable iff (rst) (!rx_en && !stat[0]) |=> !stat[0]);    // R7
endmodule

bind serial_rx_unit srx_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .rx_en   (rx_en),
    .stat_wr (stat_wr),
    .dtc_rd  (dtc_rd),
    .rx_data (rx_data),
    .stat    (stat),
    .rx_irq  (rx_irq)
);

// File: tb/sim_serial_rx_unit.sv
module sim_serial_rx_unit;
    localparam int CPT = 2;
    localparam int BP  = 16 * CPT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stat_wr = 1'b0;
    logic [3:0] stat_wdata = 4'h0;
    logic       dtc_rd = 1'b0;
    logic [7:0] rx_data;
    logic [3:0] stat;
    logic       rx_irq;
    logic       line_mon;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_rx_unit #(.CLKS_PER_TICK(CPT)) u0 (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .dtc_rd(dtc_rd), .rx_data(rx_data),
        .stat(stat), .rx_irq(rx_irq), .line_mon(line_mon)
    );

    always @(posedge clk) if (!rst && rx_irq) irq_cnt <= irq_cnt + 1;

    // {par_en, par_odd, bad_parity, bad_stop, data}
    localparam logic [11:0] VEC [8] = '{
        {4'b0000, 8'hA5}, {4'b0000, 8'h01}, {4'b1000, 8'h3C}, {4'b1100, 8'hFE},
        {4'b1010, 8'h5A}, {4'b1110, 8'h80}, {4'b0001, 8'h7E}, {4'b1001, 8'hC3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic v);
        @(negedge clk) rx_line = v;
        repeat (BP - 1) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic pe, input logic po,
                        input logic flip, input logic stopv);
        par_en = pe;
        par_odd = po;
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(d[i]);
        if (pe) bit_out((^d) ^ po ^ flip);
        bit_out(stopv);
        bit_out(1'b1);
    endtask

    task automatic wr_stat(input logic [3:0] v);
        @(negedge clk) begin stat_wr = 1'b1; stat_wdata = v; end
        @(negedge clk) stat_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] last;
        int irq_exp;
        repeat (4) @(negedge clk);
        check("R1 stat reset", stat, 4'h0);
        check("R1 data reset", rx_data, 8'h00);
        rst = 1'b0;
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 idle line", line_mon, 1'b1);
        irq_exp = 0;

        foreach (VEC[k]) begin
            logic bp, bs;
            logic [3:0] exp_s;
            bp = VEC[k][9];
            bs = VEC[k][8];
            send(VEC[k][7:0], VEC[k][11], VEC[k][10], bp, !bs);
            exp_s = {bs, bp, 1'b0, !(bp || bs)};
            if (!(bp || bs)) irq_exp++;
            check("R9 R10 R11 vector flags", stat, exp_s);
            check("R9 R10 R11 vector data", rx_data, VEC[k][7:0]);
            check("R3 irq count", irq_cnt, irq_exp);
            wr_stat(4'h0);
            check("R4 clear all", stat, 4'h0);
        end
        last = 8'hC3;

        // R4 write of ones leaves flags alone, zero clears only its bit
        send(8'h96, 1'b0, 1'b0, 1'b0, 1'b1);
        last = 8'h96;
        irq_exp++;
        wr_stat(4'hF);
        check("R4 write ones", stat, 4'b0001);
        wr_stat(4'b1110);
        check("R4 clear full only", stat, 4'b0000);

        // R5 transfer-controller read clears full
        send(8'h44, 1'b0, 1'b0, 1'b0, 1'b1);
        last = 8'h44;
        irq_exp++;
        check("R5 full before read", stat, 4'b0001);
        @(negedge clk) dtc_rd = 1'b1;
        @(negedge clk) dtc_rd = 1'b0;
        check("R5 dtc clears full", stat, 4'b0000);

        // R6 overrun keeps old data
        send(8'h21, 1'b0, 1'b0, 1'b0, 1'b1);
        last = 8'h21;
        irq_exp++;
        send(8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R6 overrun flags", stat, 4'b0011);
        check("R6 old data kept", rx_data, last);
        check("R3 no irq on overrun", irq_cnt, irq_exp);
        @(negedge clk) dtc_rd = 1'b1;
        @(negedge clk) dtc_rd = 1'b0;
        check("R5 dtc leaves overrun", stat, 4'b0010);

        // R2 lockout while an error flag is set
        send(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 locked flags", stat, 4'b0010);
        check("R2 locked data", rx_data, last);
        wr_stat(4'h0);
        send(8'h22, 1'b0, 1'b0, 1'b0, 1'b1);
        last = 8'h22;
        irq_exp++;
        check("R2 resumed flags", stat, 4'b0001);
        check("R2 resumed data", rx_data, 8'h22);
        wr_stat(4'h0);

        // R7 disabled receiver ignores the line
        rx_en = 1'b0;
        send(8'h66, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 disabled flags", stat, 4'b0000);
        check("R7 disabled data", rx_data, last);
        rx_en = 1'b1;

        // R9 a short low glitch is not a start bit
        @(negedge clk) rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (12 * BP) @(negedge clk);
        check("R9 glitch rejected", stat, 4'b0000);

        // R8 R11 break: line held low
        @(negedge clk) rx_line = 1'b0;
        repeat (12 * BP) @(negedge clk);
        check("R11 break framing", stat, 4'b1000);
        check("R11 break data", rx_data, 8'h00);
        check("R8 break line low", line_mon, 1'b0);
        rx_line = 1'b1;
        repeat (BP) @(negedge clk);
        check("R8 line released", line_mon, 1'b1);
        wr_stat(4'h0);
        check("R4 clear framing", stat, 4'b0000);
        check("R3 irq total", irq_cnt, irq_exp);
        finish_run();
    end
endmodule